// File: doc/BRIEF.md
# Multi-cycle 16-bit subset processor core

This block is a small processor core that executes a fixed set of seven 16-bit instructions: register/immediate add and AND, conditional branch, register-indirect jump, load from base plus offset, PC-relative effective address and a software trap. It runs one instruction at a time through a short state sequence (fetch request, fetch wait, execute, and for loads and traps a second request and wait) against an external word-addressed synchronous memory.

The memory port offers an address, write data, a write select, and a one-cycle request strobe. Read data and a one-cycle ready flag come back. The core sends one request at a time and does not advance until ready returns, so it tolerates any read latency of one clock or more. Addresses are reduced modulo the memory size, so a PC that runs past the last word fetches from word 0. A debug port shows the PC and all eight general registers.

The subset has no store instruction, so the core only reads. Every opcode outside the seven is fetched and then dropped.

Top module: `nzp16_core`

## Requirements
- R1: While reset is high, and after it falls until the first write, the PC and all eight registers read zero. The condition flags reset to Z, so a branch with mask z-only as the first instruction is taken.
- R2: In the first cycle after reset, `mem_en` is high with `mem_addr` equal to 0. `mem_en` is never high for two cycles in a row. The core holds its PC and state until `mem_rdy` arrives, however late it is. `mem_addr` is always the wanted address modulo `MEM_WORDS`, so the PC wraps from word 31 to word 0.
- R3: ADD (opcode 0001) writes the register selected by bits 11:9. The result is the sum of the register selected by bits 8:6 and either the register selected by bits 2:0 (bit 5 = 0) or the sign-extended immediate in bits 4:0 (bit 5 = 1).
- R4: AND (opcode 0101) uses the same operand fields as ADD and writes the bitwise AND.
- R5: ADD, AND, LDR and LEA set exactly one flag, from the 16-bit value written: n for negative, z for zero, p for positive. JMP, BR, TRAP and unknown opcodes leave the flags unchanged.
- R6: BR (opcode 0000) treats bits 11:9 as an {n,z,p} mask. It is taken when the mask and the flags share a set bit, and then loads PC+1 plus the sign-extended bits 8:0. The all-zero word does nothing.
- R7: LEA (opcode 1110) writes PC+1 plus the sign-extended bits 8:0 into the register selected by bits 11:9. At address 0 with offset -129 the result is 0xFF80.
- R8: JMP (opcode 1100) loads the PC from the register selected by bits 8:6.
- R9: LDR (opcode 0110) writes the memory word at (register selected by bits 8:6) plus the sign-extended bits 5:0 into the register selected by bits 11:9.
- R10: TRAP (opcode 1111) writes PC+1 into R7, then loads the PC from the memory word at the zero-extended bits 7:0.
- R11: All other opcodes change no register, no flag and do not redirect the PC.
- R12: `mem_we` and `mem_wdata` stay at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| mem_addr | output | 16 | Word address of the current request, modulo MEM_WORDS |
| mem_wdata | output | 16 | Write data (always zero) |
| mem_we | output | 1 | Write select (always low) |
| mem_en | output | 1 | One-cycle request strobe |
| mem_rdata | input | 16 | Read data, valid while mem_rdy is high |
| mem_rdy | input | 1 | Request completed |
| dbg_pc | output | 16 | Current program counter |
| dbg_regs | output | 128 | R0..R7, R0 in bits 15:0 |

## Verification
The flags cannot be seen at the ports, so each flag case is brought out through a branch whose mask picks exactly one flag. Whether a following marker instruction ran then shows the flag. The hardest case to reach is the address wrap. A program builds the value 31 from small immediates, jumps there, and lets the PC run to 32. A branch at word 0 that only passes on p, which the wrap-time add provides, then proves the fetch came from word 0. A bench memory with three added wait states repeats the arithmetic program to show the core waits for ready.

// File: rtl/nzp16_pkg.sv
package nzp16_pkg;
  localparam int XLEN = 16;
  localparam int NREG = 8;
  localparam int RSEL = 3;

  localparam logic [3:0] OPC_BR   = 4'b0000;
  localparam logic [3:0] OPC_ADD  = 4'b0001;
  localparam logic [3:0] OPC_AND  = 4'b0101;
  localparam logic [3:0] OPC_LDR  = 4'b0110;
  localparam logic [3:0] OPC_JMP  = 4'b1100;
  localparam logic [3:0] OPC_LEA  = 4'b1110;
  localparam logic [3:0] OPC_TRAP = 4'b1111;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [2:0] {
    PH_FETCH = 3'd0,
    PH_FWAIT = 3'd1,
    PH_EXEC  = 3'd2,
    PH_MREQ  = 3'd3,
    PH_MWAIT = 3'd4
  } phase_t;

  function automatic word_t sx5(input logic [4:0] f);
    return {{(XLEN-5){f[4]}}, f};
  endfunction

  function automatic word_t sx6(input logic [5:0] f);
    return {{(XLEN-6){f[5]}}, f};
  endfunction

  function automatic word_t sx9(input logic [8:0] f);
    return {{(XLEN-9){f[8]}}, f};
  endfunction

  function automatic word_t zx8(input logic [7:0] f);
    return {{(XLEN-8){1'b0}}, f};
  endfunction

  // {n,z,p} classification of a written value
  function automatic logic [2:0] nzp_of(input word_t v);
    if (v[XLEN-1])   return 3'b100;
    else if (v == '0) return 3'b010;
    else              return 3'b001;
  endfunction

  function automatic logic br_hit(input logic [2:0] mask, input logic [2:0] flags);
    return |(mask & flags);
  endfunction
endpackage

// File: rtl/nzp16_regfile.sv
module nzp16_regfile import nzp16_pkg::*; (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [RSEL-1:0]      wr_sel,
  input  word_t                wr_data,
  input  logic [RSEL-1:0]      rd_sel_a,
  input  logic [RSEL-1:0]      rd_sel_b,
  output word_t                rd_a,
  output word_t                rd_b,
  output logic [NREG*XLEN-1:0] snap
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    word_t q;
    always_ff @(posedge clk or posedge rst) begin
      if (rst)                                 q <= '0;
      else if (wr_en && wr_sel == RSEL'(g))    q <= wr_data;
    end
    assign snap[g*XLEN +: XLEN] = q;
  end

  assign rd_a = snap[rd_sel_a*XLEN +: XLEN];
  assign rd_b = snap[rd_sel_b*XLEN +: XLEN];

  AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> snap[$past(wr_sel)*XLEN +: XLEN] == $past(wr_data)); // R3
endmodule

// File: rtl/nzp16_alu.sv
module nzp16_alu import nzp16_pkg::*; (
  input  logic  use_and,
  input  word_t a,
  input  word_t b,
  output word_t y
);
  always_comb begin
    if (use_and) y = a & b;
    else         y = a + b;
  end
endmodule

// File: rtl/nzp16_agen.sv
module nzp16_agen import nzp16_pkg::*; (
  input  word_t       pc_inc,
  input  word_t       base,
  input  logic [8:0]  off9,
  input  logic [5:0]  off6,
  input  logic [7:0]  vec,
  output word_t       pc_rel,
  output word_t       base_off,
  output word_t       vec_addr
);
  assign pc_rel   = pc_inc + sx9(off9);
  assign base_off = base + sx6(off6);
  assign vec_addr = zx8(vec);
endmodule

// File: rtl/nzp16_core.sv
module nzp16_core import nzp16_pkg::*; #(
  parameter int MEM_WORDS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [XLEN-1:0]      mem_addr,
  output logic [XLEN-1:0]      mem_wdata,
  output logic                 mem_we,
  output logic                 mem_en,
  input  logic [XLEN-1:0]      mem_rdata,
  input  logic                 mem_rdy,
  output logic [XLEN-1:0]      dbg_pc,
  output logic [NREG*XLEN-1:0] dbg_regs
);
  localparam word_t           ADDR_MASK = word_t'(MEM_WORDS - 1);
  localparam logic [RSEL-1:0] LINK_REG  = RSEL'(NREG - 1);
  localparam logic [2:0]      FLAGS_RST = 3'b010;

  phase_t     ph_q;
  word_t      pc_q, ir_q, maddr_q;
  logic [2:0] cc_q;

  // decode fields
  logic [3:0]      opc;
  logic [RSEL-1:0] f_dst, f_src1, f_src2;
  assign opc    = ir_q[15:12];
  assign f_dst  = ir_q[11:9];
  assign f_src1 = ir_q[8:6];
  assign f_src2 = ir_q[2:0];

  // named internal events
  logic in_exec, fetch_done, mem_done, exec_trap, exec_ldr, exec_br, br_taken;
  assign in_exec    = (ph_q == PH_EXEC);
  assign fetch_done = (ph_q == PH_FWAIT) && mem_rdy;
  assign mem_done   = (ph_q == PH_MWAIT) && mem_rdy;
  assign exec_trap  = in_exec && (opc == OPC_TRAP);
  assign exec_ldr   = in_exec && (opc == OPC_LDR);
  assign exec_br    = in_exec && (opc == OPC_BR);
  assign br_taken   = exec_br && br_hit(f_dst, cc_q);

  // register file
  logic            rf_we;
  logic [RSEL-1:0] rf_sel;
  word_t           rf_wd, rd_a, rd_b;

  nzp16_regfile u_rf (
    .clk(clk), .rst(rst),
    .wr_en(rf_we), .wr_sel(rf_sel), .wr_data(rf_wd),
    .rd_sel_a(f_src1), .rd_sel_b(f_src2),
    .rd_a(rd_a), .rd_b(rd_b), .snap(dbg_regs)
  );

  // arithmetic
  word_t alu_b, alu_y;
  assign alu_b = ir_q[5] ? sx5(ir_q[4:0]) : rd_b;

  nzp16_alu u_alu (
    .use_and(opc == OPC_AND), .a(rd_a), .b(alu_b), .y(alu_y)
  );

  // address generation
  word_t pc_rel, base_off, vec_addr;
  nzp16_agen u_agen (
    .pc_inc(pc_q), .base(rd_a),
    .off9(ir_q[8:0]), .off6(ir_q[5:0]), .vec(ir_q[7:0]),
    .pc_rel(pc_rel), .base_off(base_off), .vec_addr(vec_addr)
  );

  // write-back selection
  logic cc_wr;
  always_comb begin
    rf_we  = 1'b0;
    rf_sel = f_dst;
    rf_wd  = alu_y;
    if (in_exec) begin
      case (opc)
        OPC_ADD, OPC_AND: rf_we = 1'b1;
        OPC_LEA:  begin rf_we = 1'b1; rf_wd = pc_rel; end
        OPC_TRAP: begin rf_we = 1'b1; rf_sel = LINK_REG; rf_wd = pc_q; end
        default:  rf_we = 1'b0;
      endcase
    end else if (mem_done && opc == OPC_LDR) begin
      rf_we = 1'b1;
      rf_wd = mem_rdata;
    end
  end
  assign cc_wr = rf_we && !exec_trap;

  // sequencer
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ph_q    <= PH_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      maddr_q <= '0;
      cc_q    <= FLAGS_RST;
    end else begin
      if (cc_wr) cc_q <= nzp_of(rf_wd);
      case (ph_q)
        PH_FETCH: ph_q <= PH_FWAIT;
        PH_FWAIT: if (fetch_done) begin
          ir_q <= mem_rdata;
          pc_q <= pc_q + word_t'(1);
          ph_q <= PH_EXEC;
        end
        PH_EXEC: begin
          ph_q <= PH_FETCH;
          case (opc)
            OPC_BR:   if (br_taken) pc_q <= pc_rel;
            OPC_JMP:  pc_q <= rd_a;
            OPC_LDR:  begin maddr_q <= base_off; ph_q <= PH_MREQ; end
            OPC_TRAP: begin maddr_q <= vec_addr; ph_q <= PH_MREQ; end
            default:  ;
          endcase
        end
        PH_MREQ:  ph_q <= PH_MWAIT;
        PH_MWAIT: if (mem_done) begin
          if (opc == OPC_TRAP) pc_q <= mem_rdata;
          ph_q <= PH_FETCH;
        end
        default:  ph_q <= PH_FETCH;
      endcase
    end
  end

  // memory port
  word_t mem_sel;
  assign mem_sel   = (ph_q == PH_MREQ) ? maddr_q : pc_q;
  assign mem_addr  = mem_sel & ADDR_MASK;
  assign mem_en    = (ph_q == PH_FETCH) || (ph_q == PH_MREQ);
  assign mem_we    = 1'b0;
  assign mem_wdata = '0;
  assign dbg_pc    = pc_q;

  AST_FLAGS_ONE_SET: assert property (@(posedge clk) disable iff (rst)
    $countones(cc_q) == 1); // R5
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !mem_en); // R2
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_FWAIT && !mem_rdy) |=> $stable(pc_q) && !mem_en); // R2
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> pc_q == $past(pc_rel)); // R6
  AST_TRAP_LINK: assert property (@(posedge clk) disable iff (rst)
    exec_trap |=> dbg_regs[(NREG-1)*XLEN +: XLEN] == $past(pc_q)); // R10
  AST_FLAGS_KEPT_ON_JUMP: assert property (@(posedge clk) disable iff (rst)
    (in_exec && (opc == OPC_JMP || opc == OPC_BR)) |=> $stable(cc_q)); // R5
endmodule

// File: tb/tb_nzp16_core.sv
module tb_nzp16_core;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  mem_addr, mem_wdata, mem_rdata, dbg_pc;
  logic         mem_we, mem_en, mem_rdy;
  logic [127:0] dbg_regs;

  int total = 0;
  int bad   = 0;
  int addr_bad = 0;
  int side_bad = 0;
  int lat = 0;

  logic [15:0] img [32];

  always #4 clk = ~clk;

  nzp16_core dut (
    .clk(clk), .rst(rst),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_en(mem_en),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
  );

  // memory model: ready 1+lat cycles after a request, data zero otherwise
  logic       pend;
  logic [4:0] paddr;
  int         cnt;
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      mem_rdy <= 1'b0; mem_rdata <= '0; pend <= 1'b0; paddr <= '0; cnt <= 0;
    end else begin
      mem_rdy <= 1'b0; mem_rdata <= '0;
      if (mem_we || mem_wdata != 16'h0) side_bad <= side_bad + 1;
      if (mem_en) begin
        if (mem_addr >= 16'd32) addr_bad <= addr_bad + 1;
        if (lat == 0) begin
          mem_rdy <= 1'b1; mem_rdata <= img[mem_addr[4:0]];
        end else begin
          pend <= 1'b1; paddr <= mem_addr[4:0]; cnt <= lat - 1;
        end
      end else if (pend) begin
        if (cnt == 0) begin
          mem_rdy <= 1'b1; mem_rdata <= img[paddr]; pend <= 1'b0;
        end else cnt <= cnt - 1;
      end
    end
  end

  // encoders
  function automatic logic [15:0] e_addi(input logic [2:0] d, input logic [2:0] s, input logic [4:0] i);
    return {4'b0001, d, s, 1'b1, i};
  endfunction
  function automatic logic [15:0] e_addr(input logic [2:0] d, input logic [2:0] s, input logic [2:0] t);
    return {4'b0001, d, s, 3'b000, t};
  endfunction
  function automatic logic [15:0] e_andi(input logic [2:0] d, input logic [2:0] s, input logic [4:0] i);
    return {4'b0101, d, s, 1'b1, i};
  endfunction
  function automatic logic [15:0] e_andr(input logic [2:0] d, input logic [2:0] s, input logic [2:0] t);
    return {4'b0101, d, s, 3'b000, t};
  endfunction
  function automatic logic [15:0] e_br(input logic [2:0] m, input logic [8:0] o);
    return {4'b0000, m, o};
  endfunction
  function automatic logic [15:0] e_lea(input logic [2:0] d, input logic [8:0] o);
    return {4'b1110, d, o};
  endfunction
  function automatic logic [15:0] e_jmp(input logic [2:0] b);
    return {4'b1100, 3'b000, b, 6'b000000};
  endfunction
  function automatic logic [15:0] e_ldr(input logic [2:0] d, input logic [2:0] b, input logic [5:0] o);
    return {4'b0110, d, b, o};
  endfunction
  function automatic logic [15:0] e_trap(input logic [7:0] v);
    return {4'b1111, 4'b0000, v};
  endfunction
  localparam logic [15:0] HALT = 16'h0FFF; // BR nzp -1

  function automatic logic [15:0] rv(input int i);
    return dbg_regs[i*16 +: 16];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wipe();
    for (int i = 0; i < 32; i++) img[i] = 16'h0000;
  endtask

  task automatic boot(input int l);
    rst = 1'b1; lat = l;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    wipe(); img[0] = HALT;
    rst = 1'b1; lat = 0;
    @(negedge clk);
    chk("R1 pc in reset", dbg_pc, 16'h0);
    chk("R1 R5 in reset", rv(5), 16'h0);
    rst = 1'b0; #1;
    chk("R2 first req en", {15'b0, mem_en}, 16'h1);
    chk("R2 first req addr", mem_addr, 16'h0);
    @(negedge clk);
    chk("R2 strobe drops", {15'b0, mem_en}, 16'h0);
    @(negedge clk);
    chk("R2 pc after fetch", dbg_pc, 16'h1);
  endtask

  task automatic t_reset_flags();
    wipe();
    img[0] = e_br(3'b010, 9'd1);
    img[1] = e_addi(3'd1, 3'd1, 5'd1);
    img[2] = e_addi(3'd2, 3'd2, 5'd2);
    img[3] = HALT;
    boot(0); run(60);
    chk("R1 z flag at reset, skipped", rv(1), 16'h0);
    chk("R1 after branch", rv(2), 16'h2);
  endtask

  task automatic t_arith(input int l);
    wipe();
    img[0] = e_addi(3'd1, 3'd0, 5'd5);
    img[1] = e_addi(3'd2, 3'd1, 5'h1D);  // -3
    img[2] = e_addr(3'd3, 3'd1, 3'd2);
    img[3] = e_andi(3'd4, 3'd3, 5'd6);
    img[4] = e_andr(3'd5, 3'd3, 3'd1);
    img[5] = e_addi(3'd6, 3'd0, 5'h1F);  // -1
    img[6] = e_andr(3'd7, 3'd6, 3'd3);
    img[7] = HALT;
    boot(l); run(200);
    chk("R3 add imm", rv(1), 16'd5);
    chk("R3 add neg imm", rv(2), 16'd2);
    chk("R3 add reg", rv(3), 16'd7);
    chk("R4 and imm", rv(4), 16'd6);
    chk("R4 and reg", rv(5), 16'd5);
    chk("R3 sign extend", rv(6), 16'hFFFF);
    chk("R4 and with ones", rv(7), 16'd7);
  endtask

  task automatic t_flags();
    wipe();
    img[0] = e_addi(3'd1, 3'd0, 5'h1E);  // -2 -> n
    img[1] = e_br(3'b100, 9'd1);
    img[2] = e_addi(3'd2, 3'd0, 5'd1);
    img[3] = e_br(3'b001, 9'd1);
    img[4] = e_addi(3'd3, 3'd0, 5'd3);
    img[5] = e_addi(3'd4, 3'd0, 5'd0);   // z
    img[6] = e_br(3'b010, 9'd1);
    img[7] = e_addi(3'd5, 3'd0, 5'd7);
    img[8] = HALT;
    boot(0); run(120);
    chk("R5 n flag branch taken", rv(2), 16'h0);
    chk("R6 p mask not taken", rv(3), 16'd3);
    chk("R5 z flag branch taken", rv(5), 16'h0);
  endtask

  task automatic t_loop();
    wipe();
    img[0] = e_addi(3'd1, 3'd0, 5'd3);
    img[1] = e_addi(3'd2, 3'd2, 5'd2);
    img[2] = e_addi(3'd1, 3'd1, 5'h1F);
    img[3] = e_br(3'b001, 9'h1FD);       // -3
    img[4] = 16'h0000;
    img[5] = e_addi(3'd3, 3'd0, 5'd1);
    img[6] = HALT;
    boot(0); run(150);
    chk("R6 backward loop count", rv(2), 16'd6);
    chk("R6 loop counter", rv(1), 16'd0);
    chk("R6 zero word no-op", rv(3), 16'd1);
  endtask

  task automatic t_lea();
    wipe();
    img[0] = e_lea(3'd1, 9'h17F);        // -129
    img[1] = e_br(3'b100, 9'd1);
    img[2] = e_addi(3'd3, 3'd0, 5'd1);
    img[3] = e_lea(3'd2, 9'd10);
    img[4] = HALT;
    boot(0); run(80);
    chk("R7 lea negative", rv(1), 16'hFF80);
    chk("R7 lea forward", rv(2), 16'd14);
    chk("R5 lea sets n", rv(3), 16'h0);
  endtask

  task automatic t_jmp();
    wipe();
    img[0] = e_addi(3'd1, 3'd0, 5'd6);
    img[1] = e_jmp(3'd1);
    img[2] = e_addi(3'd2, 3'd0, 5'd1);
    img[6] = e_addi(3'd3, 3'd0, 5'd3);
    img[7] = HALT;
    boot(0); run(80);
    chk("R8 jump skips", rv(2), 16'h0);
    chk("R8 jump target ran", rv(3), 16'd3);
  endtask

  task automatic t_ldr();
    wipe();
    img[0] = e_addi(3'd1, 3'd0, 5'd15);
    img[1] = e_ldr(3'd2, 3'd1, 6'd5);
    img[2] = e_br(3'b100, 9'd1);
    img[3] = e_addi(3'd3, 3'd0, 5'd1);
    img[4] = e_ldr(3'd4, 3'd1, 6'd6);
    img[5] = e_br(3'b010, 9'd1);
    img[6] = e_addi(3'd5, 3'd0, 5'd1);
    img[7] = e_ldr(3'd6, 3'd1, 6'h3F);   // -1
    img[8] = HALT;
    img[14] = 16'h1234;
    img[20] = 16'h8001;
    boot(0); run(150);
    chk("R9 load positive offset", rv(2), 16'h8001);
    chk("R5 load sets n", rv(3), 16'h0);
    chk("R9 load zero word", rv(4), 16'h0);
    chk("R5 load sets z", rv(5), 16'h0);
    chk("R9 load negative offset", rv(6), 16'h1234);
  endtask

  task automatic t_trap();
    wipe();
    img[0]  = e_addi(3'd1, 3'd0, 5'd1);
    img[1]  = e_trap(8'h17);
    img[2]  = e_addi(3'd3, 3'd0, 5'd1);
    img[23] = 16'd29;
    img[29] = e_addi(3'd2, 3'd0, 5'd5);
    img[30] = HALT;
    boot(0); run(80);
    chk("R10 link in R7", rv(7), 16'd2);
    chk("R10 vector target ran", rv(2), 16'd5);
    chk("R10 no fall through", rv(3), 16'h0);
  endtask

  task automatic t_unknown();
    wipe();
    img[0] = e_addi(3'd1, 3'd0, 5'd3);
    img[1] = 16'h9FFF;
    img[2] = 16'h2E00;
    img[3] = 16'h4801;
    img[4] = 16'hDFFF;
    img[5] = e_br(3'b001, 9'd1);
    img[6] = e_addi(3'd2, 3'd0, 5'd1);
    img[7] = HALT;
    boot(0); run(100);
    chk("R11 R7 untouched", rv(7), 16'h0);
    chk("R11 flags kept", rv(2), 16'h0);
    chk("R11 R1 intact", rv(1), 16'd3);
  endtask

  task automatic t_wrap();
    wipe();
    img[0]  = e_br(3'b001, 9'd4);
    img[1]  = e_addi(3'd1, 3'd0, 5'd15);
    img[2]  = e_addi(3'd1, 3'd1, 5'd15);
    img[3]  = e_addi(3'd1, 3'd1, 5'd1);
    img[4]  = e_jmp(3'd1);
    img[5]  = HALT;
    img[31] = e_addi(3'd2, 3'd0, 5'd4);
    boot(0); run(120);
    chk("R2 wrap pre-value", rv(1), 16'd31);
    chk("R2 wrap last word ran", rv(2), 16'd4);
    chk("R2 address stays in range", 16'(addr_bad), 16'd0);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_reset_flags();
    t_arith(0);
    t_arith(3);       // R2 wait states
    t_flags();
    t_loop();
    t_lea();
    t_jmp();
    t_ldr();
    t_trap();
    t_unknown();
    t_wrap();
    chk("R12 no write activity", 16'(side_bad), 16'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule